// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a synchronous SMBus target that holds a small bank of byte-wide configuration registers for a clock-distribution subsystem. It oversamples SCL and SDA with the system clock and finds start, repeated start and stop conditions. It pulls SDA low through an open-drain enable, both to acknowledge and to shift read data out. Every transfer names a starting register index and then a byte count. A write stores that many bytes from the index onward. A read first sets the index in a short write phase, then turns the bus round with a repeated start. The target answers with the count byte and then the register contents.

The 7-bit bus address is a fixed upper nibble joined to three strap pins, which are captured while reset is asserted. The top strap bit also sets the operating mode: 0 gives bypass (fanout) operation and 1 uses the PLL. Register 0 drives two gear-ratio select fields, one for each output group. After reset both fields read 0, which is the 1:1 ratio.

States of the controller: `ST_IDLE` waits for a start. `ST_ADDR` takes the address byte. `ST_ADDR_ACK` acknowledges it and then goes to `ST_INDEX` for a write or to `ST_TX` for a read. `ST_INDEX` and then `ST_INDEX_ACK` take the index. `ST_COUNT` and then `ST_COUNT_ACK` take the count. `ST_WDATA` and `ST_WDATA_ACK` loop once per data byte, and go to `ST_IGNORE` once the count is used up. `ST_TX` and `ST_TX_ACK` loop once per read byte, and go to `ST_IGNORE` on a host NACK. A mismatched address also goes to `ST_IGNORE`. From any state, a stop goes to `ST_IDLE` and a start goes to `ST_ADDR`.

Top module: `smbus_blk_regfile`

## Requirements
- R1: The target acknowledges an address byte equal to {ADDR_HI, strap_i[2:0] captured during reset, rw}. Here rw = 0 selects write and rw = 1 selects read, and the default ADDR_HI = 4'b1101 with straps 000 gives bytes D0h and D1h.
- R2: A mismatched address byte gets no acknowledge. No later byte up to the next start or stop is acknowledged or stored.
- R3: A write carries index N, count X and then X data bytes. Each of these bytes is acknowledged, and data byte k is stored at index N+k.
- R4: Data bytes sent after the count is used up are not acknowledged and not stored.
- R5: A read is a write of the index, then a repeated start and the read address, which the target acknowledges. The target then sends the number of implemented registers, followed by register N, N+1 and onward, MSB first.
- R6: A host NACK on a read byte ends the transfer, and the target keeps sda_oe at 0 until the next start or stop.
- R7: Writes to indices at or above NREGS are acknowledged and discarded, and reads from those indices return 00h.
- R8: After reset every register reads 00h, gear_a and gear_b are 0 (the 1:1 code), and sda_oe is 0.
- R9: pll_on equals strap_i[2] as sampled during reset, and it does not follow the strap after reset is released.
- R10: gear_a is register 0 bits [3:0] and gear_b is register 0 bits [7:4]. They change only when register 0 is written.
- R11: A stop at any point returns the controller to idle, keeping the bytes already stored. The next transfer then works normally.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while low |
| scl_i | input | 1 | SMBus clock line as seen at the pin |
| sda_i | input | 1 | SMBus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Address strap pins; bit 2 also selects the mode |
| pll_on | output | 1 | Latched mode: 1 PLL used, 0 bypass/fanout |
| gear_a | output | GEAR_W | Gear-ratio select for output group A |
| gear_b | output | GEAR_W | Gear-ratio select for output group B |

## Verification
The bench builds the block with NREGS = 6 and keeps the default ADDR_HI and GEAR_W. With six registers, a block starting at index 4 crosses the end of the bank within a few bytes, so discarded writes and 00h reads are exercised without long transfers, and the count byte returned on a read (6) differs from any count the host writes. A second reset with the top strap set moves the address to D8h/D9h, which shows both the strap-driven address match and the mode latch.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } smbr_state_e;

    typedef struct packed {
        logic scl;    // synchronized SCL level
        logic sda;    // synchronized SDA level
        logic start;  // SDA fell while SCL high
        logic stop;   // SDA rose while SCL high
        logic rise;   // SCL rising edge
        logic fall;   // SCL falling edge
    } smbr_bus_s;

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output smbr_pkg::smbr_bus_s  bus_o
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        bus_o.scl   = scl_s;
        bus_o.sda   = sda_s;
        bus_o.start = scl_s & scl_d & sda_d & ~sda_s;
        bus_o.stop  = scl_s & scl_d & ~sda_d & sda_s;
        bus_o.rise  = scl_s & ~scl_d;
        bus_o.fall  = ~scl_s & scl_d;
    end

endmodule

// File: rtl/smbr_bank.sv
module smbr_bank #(
    parameter int NREGS  = 8,
    parameter int GEAR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [7:0]        waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [7:0]        raddr_i,
    output logic [7:0]        rdata_o,
    output logic [GEAR_W-1:0] gear_a_o,
    output logic [GEAR_W-1:0] gear_b_o
);

    localparam int         IW   = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [7:0] LAST = 8'(NREGS - 1);

    logic [7:0]         regs [NREGS];
    logic [8*NREGS-1:0] flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NREGS; i++)
                if (we_i && waddr_i == 8'(i)) regs[i] <= wdata_i;
        end
    end

    always_comb begin
        for (int i = 0; i < NREGS; i++) flat[8*i +: 8] = regs[i];
    end

    assign rdata_o  = (raddr_i <= LAST) ? regs[raddr_i[IW-1:0]] : 8'h00;
    assign gear_a_o = regs[0][GEAR_W-1:0];
    assign gear_b_o = regs[0][2*GEAR_W-1:GEAR_W];

    // R7: a write past the last register leaves the whole bank untouched
    assert_beyond_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i > LAST) |=> $stable(flat));

    // R10: gear fields hold unless register 0 is written
    assert_gear_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && waddr_i == 8'h00) |=> $stable({gear_b_o, gear_a_o}));

    // R10: a write to register 0 lands on the gear fields
    assert_gear_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == 8'h00) |=> ({gear_b_o, gear_a_o} == $past(wdata_i[2*GEAR_W-1:0])));

endmodule

// File: rtl/smbr_fsm.sv
module smbr_fsm #(
    parameter int NREGS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  smbr_pkg::smbr_bus_s bus_i,
    input  logic [6:0]          my_addr_i,
    input  logic [7:0]          rdata_i,
    output logic                we_o,
    output logic [7:0]          waddr_o,
    output logic [7:0]          wdata_o,
    output logic [7:0]          raddr_o,
    output logic                sda_oe_o
);
    import smbr_pkg::*;

    localparam logic [7:0] COUNT_BYTE = 8'(NREGS);

    smbr_state_e state_q, state_d;
    logic [7:0]  sr;
    logic [2:0]  cnt;
    logic        got8;
    logic [7:0]  ptr;
    logic [7:0]  remain;
    logic        rw_q;
    logic        host_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_i.stop) begin
            state_d = ST_IDLE;
        end else if (bus_i.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:
                    if (bus_i.fall && got8)
                        state_d = (sr[7:1] == my_addr_i) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (bus_i.fall) state_d = rw_q ? ST_TX : ST_INDEX;
                ST_INDEX:
                    if (bus_i.fall && got8) state_d = ST_INDEX_ACK;
                ST_INDEX_ACK:
                    if (bus_i.fall) state_d = ST_COUNT;
                ST_COUNT:
                    if (bus_i.fall && got8) state_d = ST_COUNT_ACK;
                ST_COUNT_ACK:
                    if (bus_i.fall) state_d = ST_WDATA;
                ST_WDATA:
                    if (bus_i.fall && got8)
                        state_d = (remain != 8'h00) ? ST_WDATA_ACK : ST_IGNORE;
                ST_WDATA_ACK:
                    if (bus_i.fall) state_d = ST_WDATA;
                ST_TX:
                    if (bus_i.fall && cnt == 3'd7) state_d = ST_TX_ACK;
                ST_TX_ACK:
                    if (bus_i.fall) state_d = host_ack ? ST_TX : ST_IGNORE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= 8'h00;
            cnt      <= 3'd0;
            got8     <= 1'b0;
            ptr      <= 8'h00;
            remain   <= 8'h00;
            rw_q     <= 1'b0;
            host_ack <= 1'b0;
        end else if (bus_i.start || bus_i.stop) begin
            cnt  <= 3'd0;
            got8 <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (bus_i.rise && !got8) begin
                        sr  <= {sr[6:0], bus_i.sda};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) got8 <= 1'b1;
                    end
                    if (bus_i.fall && got8) begin
                        got8 <= 1'b0;
                        cnt  <= 3'd0;
                        case (state_q)
                            ST_ADDR:  rw_q   <= sr[0];
                            ST_INDEX: ptr    <= sr;
                            ST_COUNT: remain <= sr;
                            default: begin
                                if (remain != 8'h00) begin
                                    ptr    <= ptr + 8'd1;
                                    remain <= remain - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (bus_i.fall && rw_q) begin
                        sr  <= COUNT_BYTE;
                        cnt <= 3'd0;
                    end
                end
                ST_TX: begin
                    if (bus_i.fall) begin
                        sr  <= {sr[6:0], 1'b0};
                        cnt <= cnt + 3'd1;
                    end
                end
                ST_TX_ACK: begin
                    if (bus_i.rise) host_ack <= ~bus_i.sda;
                    if (bus_i.fall && host_ack) begin
                        sr  <= rdata_i;
                        ptr <= ptr + 8'd1;
                        cnt <= 3'd0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_TX:   sda_oe_o = ~sr[7];
            default: sda_oe_o = 1'b0;
        endcase
        we_o    = (state_q == ST_WDATA) && bus_i.fall && got8 && (remain != 8'h00);
        waddr_o = ptr;
        wdata_o = sr;
        raddr_o = ptr;
    end

    // R11: a stop always lands in idle
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_i.stop |=> (state_q == ST_IDLE));

    // R11: a start always restarts address reception
    assert_start_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_i.start |=> (state_q == ST_ADDR));

    // R12: the open-drain enable only moves after SCL was seen low
    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(bus_i.scl));

endmodule

// File: rtl/smbus_blk_regfile.sv
module smbus_blk_regfile #(
    parameter int         NREGS       = 8,
    parameter int         GEAR_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    output logic              pll_on,
    output logic [GEAR_W-1:0] gear_a,
    output logic [GEAR_W-1:0] gear_b
);

    smbr_pkg::smbr_bus_s bus;
    logic [2:0] strap_q;
    logic       we;
    logic [7:0] waddr, wdata, raddr, rdata;

    // straps are captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end

    assign pll_on = strap_q[2];

    smbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .bus_o (bus)
    );

    smbr_fsm #(.NREGS(NREGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_i     (bus),
        .my_addr_i ({ADDR_HI, strap_q}),
        .rdata_i   (rdata),
        .we_o      (we),
        .waddr_o   (waddr),
        .wdata_o   (wdata),
        .raddr_o   (raddr),
        .sda_oe_o  (sda_oe)
    );

    smbr_bank #(.NREGS(NREGS), .GEAR_W(GEAR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (we),
        .waddr_i  (waddr),
        .wdata_i  (wdata),
        .raddr_i  (raddr),
        .rdata_o  (rdata),
        .gear_a_o (gear_a),
        .gear_b_o (gear_b)
    );

    // R9: the mode flag never moves once reset is released
    assert_pll_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pll_on));

endmodule

// File: tb/sim_smbus_blk_regfile.sv
`timescale 1ns/1ps
module sim_smbus_blk_regfile;

    localparam int NR = 6;
    localparam int Q  = 8;
    // {index, count, first data byte}
    localparam logic [23:0] VEC [0:3] = '{
        24'h00_01_21,
        24'h01_03_A0,
        24'h04_04_5C,
        24'h02_02_3F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       sda_oe, pll_on, sda_line;
    logic [3:0] gear_a, gear_b;

    int nchk = 0;
    int nerr = 0;
    int r12_bad = 0;
    logic oe_prev = 1'b0;

    logic [7:0]  mdl [0:NR-1];
    logic [15:0] wacks;
    logic [2:0]  racks;
    logic [7:0]  rcnt;
    logic [7:0]  rbuf [0:15];
    logic        rel_oe, rel_line;

    assign sda_line = sda_h & ~sda_oe;

    always #4 clk = ~clk;

    smbus_blk_regfile #(.NREGS(NR)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (strap),
        .pll_on  (pll_on),
        .gear_a  (gear_a),
        .gear_b  (gear_b)
    );

    // R12 monitor: enable may only move while SCL is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) r12_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bstart();
        sda_h = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_h = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bstop();
        sda_h = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            scl = 1'b0;   tick(Q);
        end
        sda_h = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q/2);
        ack = ~sda_line; tick(Q/2);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q/2);
            b[i] = sda_line; tick(Q/2);
            scl = 1'b0;
        end
        tick(Q);
        sda_h = ~give_ack; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    task automatic wr_block(input logic [7:0] ab, input logic [7:0] idx, input logic [7:0] cnt,
                            input int n, input logic [7:0] base);
        logic a;
        wacks = '0;
        bstart();
        wbyte(ab, a);  wacks[0] = a;
        wbyte(idx, a); wacks[1] = a;
        wbyte(cnt, a); wacks[2] = a;
        for (int k = 0; k < n; k++) begin
            wbyte(base + 8'(k), a);
            wacks[3+k] = a;
        end
        bstop();
    endtask

    task automatic rd_block(input logic [7:0] wa, input logic [7:0] ra, input logic [7:0] idx,
                            input int n);
        logic a;
        logic [7:0] b;
        racks = '0;
        bstart();
        wbyte(wa, a);  racks[0] = a;
        wbyte(idx, a); racks[1] = a;
        bstart();
        wbyte(ra, a);  racks[2] = a;
        rbyte(n > 0, b); rcnt = b;
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, b);
            rbuf[k] = b;
        end
        tick(2);
        rel_oe = sda_oe;
        rel_line = sda_line;
        bstop();
    endtask

    task automatic mdl_wr(input logic [7:0] idx, input int cnt, input int n, input logic [7:0] base);
        for (int k = 0; k < n && k < cnt; k++)
            if (int'(idx) + k < NR) mdl[int'(idx) + k] = base + 8'(k);
    endtask

    function automatic logic [7:0] mexp(input int i);
        return (i < NR) ? mdl[i] : 8'h00;
    endfunction

    function automatic logic [31:0] wmask(input int cnt, input int n);
        logic [31:0] m = 32'h7;
        for (int k = 0; k < n; k++) if (k < cnt) m[3+k] = 1'b1;
        return m;
    endfunction

    task automatic reset_dut(input logic [2:0] s);
        rst_n = 1'b0; strap = s; scl = 1'b1; sda_h = 1'b1;
        for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] idx, cnt, base;

        // R8 / R9: reset state with straps 000
        reset_dut(3'b000);
        chk("R8 sda_oe after reset", 32'(sda_oe), 32'h0);
        chk("R8 gear_a after reset", 32'(gear_a), 32'h0);
        chk("R8 gear_b after reset", 32'(gear_b), 32'h0);
        chk("R9 pll_on with strap2=0", 32'(pll_on), 32'h0);
        rd_block(8'hD0, 8'hD1, 8'h00, NR);
        chk("R1 D0/D1 acks", 32'(racks), 32'h7);
        chk("R5 count byte", 32'(rcnt), NR);
        for (int k = 0; k < NR; k++) chk("R8 register reset value", 32'(rbuf[k]), 32'h0);

        // table of block writes each followed by read-back
        for (int v = 0; v < 4; v++) begin
            idx = VEC[v][23:16]; cnt = VEC[v][15:8]; base = VEC[v][7:0];
            wr_block(8'hD0, idx, cnt, int'(cnt), base);
            mdl_wr(idx, int'(cnt), int'(cnt), base);
            if (int'(idx) + int'(cnt) > NR)
                chk("R7 beyond-end write acked", 32'(wacks), wmask(int'(cnt), int'(cnt)));
            else
                chk("R3 write acks", 32'(wacks), wmask(int'(cnt), int'(cnt)));
            rd_block(8'hD0, 8'hD1, idx, int'(cnt));
            chk("R5 read acks", 32'(racks), 32'h7);
            chk("R5 count byte", 32'(rcnt), NR);
            for (int k = 0; k < int'(cnt); k++) begin
                if (int'(idx) + k >= NR)
                    chk("R7 read beyond end", 32'(rbuf[k]), 32'h0);
                else
                    chk("R5 R3 read data", 32'(rbuf[k]), 32'(mexp(int'(idx) + k)));
            end
            chk("R6 released after NACK", 32'({rel_oe, rel_line}), 32'h1);
            if (v == 0) begin
                chk("R10 gear_a from reg0", 32'(gear_a), 32'h1);
                chk("R10 gear_b from reg0", 32'(gear_b), 32'h2);
            end
        end

        // R4: an extra byte past the count
        wr_block(8'hD0, 8'h00, 8'h01, 2, 8'h55);
        mdl_wr(8'h00, 1, 2, 8'h55);
        chk("R4 extra byte not acked", 32'(wacks), wmask(1, 2));
        rd_block(8'hD0, 8'hD1, 8'h00, 2);
        chk("R4 reg0 stored", 32'(rbuf[0]), 32'h55);
        chk("R4 reg1 untouched", 32'(rbuf[1]), 32'(mexp(1)));
        chk("R10 gear fields follow reg0", 32'({gear_b, gear_a}), 32'h55);

        // R11: stop in the middle of a write, then a normal write
        wr_block(8'hD0, 8'h03, 8'h02, 1, 8'hEE);
        mdl_wr(8'h03, 2, 1, 8'hEE);
        chk("R11 aborted write acks", 32'(wacks), wmask(2, 1));
        wr_block(8'hD0, 8'h04, 8'h01, 1, 8'h99);
        mdl_wr(8'h04, 1, 1, 8'h99);
        chk("R11 next write acks", 32'(wacks), wmask(1, 1));
        rd_block(8'hD0, 8'hD1, 8'h03, 3);
        chk("R11 reg3 kept", 32'(rbuf[0]), 32'hEE);
        chk("R11 reg4 written", 32'(rbuf[1]), 32'h99);
        chk("R11 reg5 untouched", 32'(rbuf[2]), 32'(mexp(5)));
        chk("R12 no enable change while SCL high", r12_bad, 0);

        // second reset with strap 100: address D8/D9, PLL mode
        reset_dut(3'b100);
        chk("R9 pll_on with strap2=1", 32'(pll_on), 32'h1);
        chk("R8 gear reset again", 32'({gear_b, gear_a}), 32'h0);
        wr_block(8'hD0, 8'h00, 8'h01, 1, 8'h77);
        chk("R2 mismatched address ignored", 32'(wacks), 32'h0);
        strap = 3'b000;
        tick(4);
        chk("R9 pll_on ignores strap after reset", 32'(pll_on), 32'h1);
        rd_block(8'hD8, 8'hD9, 8'h00, 1);
        chk("R1 strap address acked", 32'(racks), 32'h7);
        chk("R2 register unchanged", 32'(rbuf[0]), 32'h00);
        chk("R12 no enable change while SCL high", r12_bad, 0);

        finish_run();
    end

endmodule